// File: doc/BRIEF.md
# Serial Port Word Queue Pair

This block holds the word buffering between a processor bus and a serial shift engine. It contains two independent first-in first-out queues. The outbound queue is filled by the bus and emptied by the shifter. The inbound queue is filled by the shifter and emptied by the bus. Each queue reports its fill count and its read and write positions. Each queue also drives a request line derived from a two-bit threshold code. The inbound request counts occupied slots. The outbound request counts vacant slots.

The request lines feed the interrupt logic directly. When the DMA enable input is high they are also copied onto separate DMA request outputs. A queue that is pushed while full raises a one-cycle overrun pulse. A queue that is popped while empty raises a one-cycle illegal-access pulse. Either queue can be emptied with a flush strobe, and a soft reset strobe empties both. The serial shifter and the register decode sit outside this block.

Top module: `serial_fifo_pair`

## Requirements
- R1: After rst_n is sampled low, both counts and all four pointers read 0, the four error pulses are 0, rx_req is 0 and tx_req is 1 (threshold code 0).
- R2: Each queue returns words in the order they were accepted. The count rises by one per accepted push and falls by one per accepted pop. A push and a pop accepted in the same cycle leave the count unchanged.
- R3: A write pointer advances by one per accepted push and a read pointer by one per accepted pop, wrapping from DEPTH-1 to 0. Each pointer is presented zero-extended to the status width.
- R4: rx_req is high when rx_count is at least 1, 2, 4 or DEPTH for rx_thr codes 0, 1, 2 and 3 respectively.
- R5: tx_req is high when DEPTH minus tx_count is at least 1, 2, 4 or DEPTH for tx_thr codes 0, 1, 2 and 3 respectively.
- R6: rx_dma_req and tx_dma_req equal rx_req and tx_req while dma_en is 1, and are 0 while dma_en is 0.
- R7: A flush strobe on one queue leaves that queue's count and pointers at 0 after the edge. The other queue is untouched. A push or pop to the flushed queue in the same cycle is ignored and raises no pulse.
- R8: soft_rst empties both queues in the same way as two flushes.
- R9: A push to a full queue is discarded. Its count, pointers and head word stay unchanged, and its overrun pulse is high for the one cycle after that edge (tx for bus writes, rx for shifter writes).
- R10: A pop from an empty queue is discarded. Its count and pointers stay unchanged, and its illegal-access pulse is high for the one cycle after that edge (rx for bus reads, tx for shifter reads).
- R11: Counts, pointers and pulses are registered: they change only at the clock edge that samples the access. Requests follow the count without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Empty both queues |
| tx_flush | input | 1 | Empty the outbound queue |
| rx_flush | input | 1 | Empty the inbound queue |
| rx_thr | input | 2 | Inbound threshold code |
| tx_thr | input | 2 | Outbound threshold code |
| dma_en | input | 1 | Copy requests to the DMA outputs |
| bus_tx_wr | input | 1 | Bus push to the outbound queue |
| bus_tx_wdata | input | DATA_W | Word pushed by the bus |
| bus_rx_rd | input | 1 | Bus pop from the inbound queue |
| bus_rx_rdata | output | DATA_W | Inbound head word |
| sh_tx_pop | input | 1 | Shifter pop from the outbound queue |
| sh_tx_data | output | DATA_W | Outbound head word |
| sh_rx_push | input | 1 | Shifter push to the inbound queue |
| sh_rx_wdata | input | DATA_W | Word pushed by the shifter |
| rx_req | output | 1 | Inbound threshold request |
| tx_req | output | 1 | Outbound threshold request |
| rx_dma_req | output | 1 | Inbound DMA request |
| tx_dma_req | output | 1 | Outbound DMA request |
| rx_ovr_pulse | output | 1 | Inbound overrun pulse |
| tx_ovr_pulse | output | 1 | Outbound overrun pulse |
| rx_ill_pulse | output | 1 | Inbound illegal-access pulse |
| tx_ill_pulse | output | 1 | Outbound illegal-access pulse |
| rx_count | output | ST_W | Inbound fill count |
| rx_rptr | output | ST_W | Inbound read pointer |
| rx_wptr | output | ST_W | Inbound write pointer |
| tx_count | output | ST_W | Outbound fill count |
| tx_rptr | output | ST_W | Outbound read pointer |
| tx_wptr | output | ST_W | Outbound write pointer |

## Verification
Counts, pointers and error pulses are due one clock edge after the access that causes them. A pulse stays visible only until the following edge. Requests, DMA requests and head words are combinational from the registered state, so they are valid in the same cycle as the new count. The bench drives every strobe 1 ns after a rising edge. It samples 1 ns after the next rising edge, which is the first point where a registered result is due, and it checks one value before that edge to show nothing moved early. It then makes one idle step to confirm each pulse has dropped.

// File: rtl/sfp_pkg.sv
// Shared types for the serial word queue pair.
// Assumes: DEPTH of at least 4 so that every threshold code is reachable.
package sfp_pkg;

    localparam int unsigned SFP_DATA_W = 32;
    localparam int unsigned SFP_DEPTH  = 8;

    // Threshold codes; the numeric value is the encoding on rx_thr/tx_thr.
    typedef enum logic [1:0] {
        THR_ONE  = 2'd0,
        THR_TWO  = 2'd1,
        THR_FOUR = 2'd2,
        THR_ALL  = 2'd3
    } thr_code_e;

    // Which quantity a level comparator measures.
    typedef enum logic {
        CMP_FILLED = 1'b0,
        CMP_VACANT = 1'b1
    } cmp_kind_e;

endpackage

// File: rtl/sfp_fifo.sv
// Single synchronous word queue with fill count, exposed pointers and
// one-cycle overrun / illegal-pop pulses.
// Assumes: clear has priority over push and pop in the same cycle; a push
// when full or a pop when empty is dropped without touching state.
module sfp_fifo #(
    parameter  int unsigned DATA_W = 32,
    parameter  int unsigned DEPTH  = 8,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic [AW-1:0]     rptr,
    output logic [AW-1:0]     wptr,
    output logic              ovr_pulse,
    output logic              ill_pulse
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic full, empty, push_ok, pop_ok;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept or reject the two accesses.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full && !clear;
        pop_ok  = pop && !empty && !clear;
    end

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_data;
        end
    end

    assign head = mem[rptr];

    // Pointers, count and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rptr      <= '0;
            wptr      <= '0;
            count     <= '0;
            ovr_pulse <= 1'b0;
            ill_pulse <= 1'b0;
        end else begin
            if (push_ok) wptr <= ptr_next(wptr);
            if (pop_ok)  rptr <= ptr_next(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            ovr_pulse <= push && full;
            ill_pulse <= pop && empty;
        end
    end

    // R2: count never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R9: a lone push to a full queue leaves it full with the write pointer held.
    a_r9_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && $stable(wptr)));

    // R9: an overrun pulse is only ever caused by a push into a full queue.
    a_r9_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> ($past(push) && $past(count) == CW'(DEPTH)));

    // R10: an illegal pulse is only ever caused by a pop from an empty queue.
    a_r10_ill_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ill_pulse |-> ($past(pop) && $past(count) == '0));

    // R7: a clear leaves the queue empty with both pointers at zero.
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && rptr == '0 && wptr == '0 && !ovr_pulse && !ill_pulse));

endmodule

// File: rtl/sfp_level_cmp.sv
// Decodes a two-bit threshold code into a slot level and compares it with
// either the filled or the vacant slot count of a queue.
// Assumes: DEPTH >= 4; count is in 0..DEPTH.
module sfp_level_cmp #(
    parameter  int unsigned          DEPTH = 8,
    parameter  sfp_pkg::cmp_kind_e   KIND  = sfp_pkg::CMP_FILLED,
    localparam int unsigned          CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    code,
    output logic          req
);

    logic [CW-1:0] level;

    // Map the code onto a slot level.
    always_comb begin
        case (sfp_pkg::thr_code_e'(code))
            sfp_pkg::THR_ONE:  level = CW'(1);
            sfp_pkg::THR_TWO:  level = CW'(2);
            sfp_pkg::THR_FOUR: level = CW'(4);
            default:           level = CW'(DEPTH);
        endcase
    end

    generate
        if (KIND == sfp_pkg::CMP_FILLED) begin : g_filled
            assign req = (count >= level);
        end else begin : g_vacant
            assign req = ((CW'(DEPTH) - count) >= level);
        end
    endgenerate

endmodule

// File: rtl/serial_fifo_pair.sv
// Outbound and inbound word queues for a serial port, with threshold
// requests, DMA request gating and per-queue flush.
// Assumes: bus pushes outbound / pops inbound; shifter does the reverse;
// soft_rst and flush strobes are single-cycle and override accesses.
module serial_fifo_pair #(
    parameter  int unsigned DATA_W = sfp_pkg::SFP_DATA_W,
    parameter  int unsigned DEPTH  = sfp_pkg::SFP_DEPTH,
    localparam int unsigned ST_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic [1:0]        rx_thr,
    input  logic [1:0]        tx_thr,
    input  logic              dma_en,
    input  logic              bus_tx_wr,
    input  logic [DATA_W-1:0] bus_tx_wdata,
    input  logic              bus_rx_rd,
    output logic [DATA_W-1:0] bus_rx_rdata,
    input  logic              sh_tx_pop,
    output logic [DATA_W-1:0] sh_tx_data,
    input  logic              sh_rx_push,
    input  logic [DATA_W-1:0] sh_rx_wdata,
    output logic              rx_req,
    output logic              tx_req,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              rx_ovr_pulse,
    output logic              tx_ovr_pulse,
    output logic              rx_ill_pulse,
    output logic              tx_ill_pulse,
    output logic [ST_W-1:0]   rx_count,
    output logic [ST_W-1:0]   rx_rptr,
    output logic [ST_W-1:0]   rx_wptr,
    output logic [ST_W-1:0]   tx_count,
    output logic [ST_W-1:0]   tx_rptr,
    output logic [ST_W-1:0]   tx_wptr
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic          rx_clear, tx_clear;
    logic [AW-1:0] rx_rp, rx_wp, tx_rp, tx_wp;

    // Flush strobes merged with the soft reset.
    always_comb begin
        rx_clear = soft_rst || rx_flush;
        tx_clear = soft_rst || tx_flush;
    end

    sfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .push      (sh_rx_push),
        .push_data (sh_rx_wdata),
        .pop       (bus_rx_rd),
        .head      (bus_rx_rdata),
        .count     (rx_count),
        .rptr      (rx_rp),
        .wptr      (rx_wp),
        .ovr_pulse (rx_ovr_pulse),
        .ill_pulse (rx_ill_pulse)
    );

    sfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .push      (bus_tx_wr),
        .push_data (bus_tx_wdata),
        .pop       (sh_tx_pop),
        .head      (sh_tx_data),
        .count     (tx_count),
        .rptr      (tx_rp),
        .wptr      (tx_wp),
        .ovr_pulse (tx_ovr_pulse),
        .ill_pulse (tx_ill_pulse)
    );

    sfp_level_cmp #(.DEPTH(DEPTH), .KIND(sfp_pkg::CMP_FILLED)) u_rx_cmp (
        .count (rx_count),
        .code  (rx_thr),
        .req   (rx_req)
    );

    sfp_level_cmp #(.DEPTH(DEPTH), .KIND(sfp_pkg::CMP_VACANT)) u_tx_cmp (
        .count (tx_count),
        .code  (tx_thr),
        .req   (tx_req)
    );

    // Zero-extend pointers and gate DMA requests.
    always_comb begin
        rx_rptr    = ST_W'(rx_rp);
        rx_wptr    = ST_W'(rx_wp);
        tx_rptr    = ST_W'(tx_rp);
        tx_wptr    = ST_W'(tx_wp);
        rx_dma_req = dma_en && rx_req;
        tx_dma_req = dma_en && tx_req;
    end

    // R4: the all-slots code requests only on a full inbound queue.
    a_r4_rx_all_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_thr == 2'd3 && rx_req) |-> (rx_count == ST_W'(DEPTH)));

    // R5: code 0 requests whenever the outbound queue is not full.
    a_r5_tx_one_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_thr == 2'd0) |-> (tx_req == (tx_count != ST_W'(DEPTH))));

    // R6: no DMA request while DMA is disabled.
    a_r6_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!rx_dma_req && !tx_dma_req));

    // R8: soft reset empties both queues.
    a_r8_soft_both: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rx_count == '0 && tx_count == '0));

endmodule

// File: tb/serial_fifo_pair_tb_top.sv
// Directed bench for serial_fifo_pair: one task per scenario.
module serial_fifo_pair_tb_top;

    localparam int DW = 32;
    localparam int DP = 8;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n, soft_rst, tx_flush, rx_flush, dma_en;
    logic [1:0] rx_thr, tx_thr;
    logic bus_tx_wr, bus_rx_rd, sh_tx_pop, sh_rx_push;
    logic [DW-1:0] bus_tx_wdata, sh_rx_wdata, bus_rx_rdata, sh_tx_data;
    logic rx_req, tx_req, rx_dma_req, tx_dma_req;
    logic rx_ovr_pulse, tx_ovr_pulse, rx_ill_pulse, tx_ill_pulse;
    logic [SW-1:0] rx_count, rx_rptr, rx_wptr, tx_count, tx_rptr, tx_wptr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    serial_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_flush(tx_flush),
        .rx_flush(rx_flush), .rx_thr(rx_thr), .tx_thr(tx_thr), .dma_en(dma_en),
        .bus_tx_wr(bus_tx_wr), .bus_tx_wdata(bus_tx_wdata), .bus_rx_rd(bus_rx_rd),
        .bus_rx_rdata(bus_rx_rdata), .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
        .sh_rx_push(sh_rx_push), .sh_rx_wdata(sh_rx_wdata), .rx_req(rx_req),
        .tx_req(tx_req), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_ovr_pulse(rx_ovr_pulse), .tx_ovr_pulse(tx_ovr_pulse),
        .rx_ill_pulse(rx_ill_pulse), .tx_ill_pulse(tx_ill_pulse),
        .rx_count(rx_count), .rx_rptr(rx_rptr), .rx_wptr(rx_wptr),
        .tx_count(tx_count), .tx_rptr(tx_rptr), .tx_wptr(tx_wptr)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int lvl(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : DP;
    endfunction

    task automatic bus_push(input logic [DW-1:0] d);
        bus_tx_wr = 1'b1; bus_tx_wdata = d; tick(); bus_tx_wr = 1'b0;
    endtask

    task automatic sh_push(input logic [DW-1:0] d);
        sh_rx_push = 1'b1; sh_rx_wdata = d; tick(); sh_rx_push = 1'b0;
    endtask

    task automatic sh_pop_chk(input logic [DW-1:0] exp);
        chk("R2", "tx head", sh_tx_data, exp);
        sh_tx_pop = 1'b1; tick(); sh_tx_pop = 1'b0;
    endtask

    task automatic bus_pop_chk(input logic [DW-1:0] exp);
        chk("R2", "rx head", bus_rx_rdata, exp);
        bus_rx_rd = 1'b1; tick(); bus_rx_rd = 1'b0;
    endtask

    task automatic flush_rx();
        rx_flush = 1'b1; tick(); rx_flush = 1'b0;
    endtask

    task automatic flush_tx();
        tx_flush = 1'b1; tick(); tx_flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rx_count", rx_count, 0);
        chk("R1", "tx_count", tx_count, 0);
        chk("R1", "ptrs", {rx_rptr, rx_wptr, tx_rptr, tx_wptr}, 0);
        chk("R1", "pulses", {rx_ovr_pulse, tx_ovr_pulse, rx_ill_pulse, tx_ill_pulse}, 0);
        chk("R1", "rx_req", rx_req, 0);
        chk("R1", "tx_req", tx_req, 1);
    endtask

    task automatic t_order();
        bus_tx_wr = 1'b1; bus_tx_wdata = 32'h11;
        #1 chk("R11", "tx_count before edge", tx_count, 0);
        tick(); bus_tx_wr = 1'b0;
        chk("R11", "tx_count after edge", tx_count, 1);
        bus_push(32'h22);
        bus_push(32'h33);
        chk("R2", "tx_count", tx_count, 3);
        chk("R3", "tx_wptr", tx_wptr, 3);
        chk("R3", "tx_rptr", tx_rptr, 0);
        sh_pop_chk(32'h11);
        chk("R3", "tx_rptr after pop", tx_rptr, 1);
        bus_tx_wr = 1'b1; bus_tx_wdata = 32'h44; sh_tx_pop = 1'b1;
        tick(); bus_tx_wr = 1'b0; sh_tx_pop = 1'b0;
        chk("R2", "tx_count push+pop", tx_count, 2);
        sh_pop_chk(32'h33);
        sh_pop_chk(32'h44);
        chk("R2", "tx drained", tx_count, 0);
        sh_push(32'h5A);
        sh_push(32'h5B);
        chk("R2", "rx_count", rx_count, 2);
        bus_pop_chk(32'h5A);
        bus_pop_chk(32'h5B);
        chk("R2", "rx drained", rx_count, 0);
    endtask

    task automatic t_wrap();
        flush_rx();
        for (int k = 1; k <= 10; k++) begin
            sh_push(32'hC00 + k);
            chk("R3", "rx_wptr wrap", rx_wptr, k % DP);
            bus_pop_chk(32'hC00 + k);
            chk("R3", "rx_rptr wrap", rx_rptr, k % DP);
        end
    endtask

    task automatic t_rx_thr();
        for (int code = 0; code < 4; code++) begin
            flush_rx();
            rx_thr = 2'(code);
            for (int n = 0; n <= DP; n++) begin
                #0 chk("R4", $sformatf("rx_req code%0d n%0d", code, n), rx_req, (n >= lvl(code)) ? 1 : 0);
                if (n < DP) sh_push(32'hB0 + n);
            end
        end
    endtask

    task automatic t_tx_thr();
        for (int code = 0; code < 4; code++) begin
            flush_tx();
            tx_thr = 2'(code);
            for (int n = 0; n <= DP; n++) begin
                chk("R5", $sformatf("tx_req code%0d n%0d", code, n), tx_req, ((DP - n) >= lvl(code)) ? 1 : 0);
                if (n < DP) bus_push(32'hA0 + n);
            end
        end
    endtask

    task automatic t_dma();
        // rx full with code 3 -> rx_req 1; tx full with code 3 -> tx_req 0.
        dma_en = 1'b0; #1;
        chk("R6", "rx_dma off", rx_dma_req, 0);
        chk("R6", "tx_dma off", tx_dma_req, 0);
        dma_en = 1'b1; #1;
        chk("R6", "rx_dma on", rx_dma_req, 1);
        chk("R6", "tx_dma on", tx_dma_req, 0);
        dma_en = 1'b0;
    endtask

    task automatic t_overrun();
        bus_push(32'hDEAD);
        chk("R9", "tx_ovr_pulse", tx_ovr_pulse, 1);
        chk("R9", "tx_count held", tx_count, DP);
        chk("R9", "tx_wptr held", tx_wptr, 0);
        chk("R9", "tx head held", sh_tx_data, 32'hA0);
        tick();
        chk("R9", "tx_ovr one cycle", tx_ovr_pulse, 0);
        sh_push(32'hBEEF);
        chk("R9", "rx_ovr_pulse", rx_ovr_pulse, 1);
        chk("R9", "rx_count held", rx_count, DP);
        chk("R9", "rx head held", bus_rx_rdata, 32'hB0);
        tick();
        chk("R9", "rx_ovr one cycle", rx_ovr_pulse, 0);
    endtask

    task automatic t_illegal();
        flush_rx();
        flush_tx();
        bus_rx_rd = 1'b1; tick(); bus_rx_rd = 1'b0;
        chk("R10", "rx_ill_pulse", rx_ill_pulse, 1);
        chk("R10", "rx state held", {rx_count, rx_rptr, rx_wptr}, 0);
        tick();
        chk("R10", "rx_ill one cycle", rx_ill_pulse, 0);
        sh_tx_pop = 1'b1; tick(); sh_tx_pop = 1'b0;
        chk("R10", "tx_ill_pulse", tx_ill_pulse, 1);
        chk("R10", "tx state held", {tx_count, tx_rptr, tx_wptr}, 0);
    endtask

    task automatic t_flush();
        sh_push(32'h1); sh_push(32'h2); sh_push(32'h3);
        bus_push(32'h7); bus_push(32'h8);
        rx_flush = 1'b1; bus_rx_rd = 1'b1; sh_rx_push = 1'b1;
        tick();
        rx_flush = 1'b0; bus_rx_rd = 1'b0; sh_rx_push = 1'b0;
        chk("R7", "rx_count flushed", rx_count, 0);
        chk("R7", "rx ptrs flushed", {rx_rptr, rx_wptr}, 0);
        chk("R7", "no pulse on flush", {rx_ovr_pulse, rx_ill_pulse}, 0);
        chk("R7", "tx untouched", tx_count, 2);
        chk("R7", "tx wptr untouched", tx_wptr, 2);
        flush_tx();
        chk("R7", "tx_count flushed", tx_count, 0);
    endtask

    task automatic t_soft();
        sh_push(32'h9);
        bus_push(32'hA);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk("R8", "rx_count soft", rx_count, 0);
        chk("R8", "tx_count soft", tx_count, 0);
        chk("R8", "ptrs soft", {rx_rptr, rx_wptr, tx_rptr, tx_wptr}, 0);
        chk("R8", "tx_req after soft", tx_req, 1);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; tx_flush = 1'b0; rx_flush = 1'b0;
        dma_en = 1'b0; rx_thr = 2'd0; tx_thr = 2'd0;
        bus_tx_wr = 1'b0; bus_rx_rd = 1'b0; sh_tx_pop = 1'b0; sh_rx_push = 1'b0;
        bus_tx_wdata = '0; sh_rx_wdata = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_order();
        t_wrap();
        t_rx_thr();
        t_tx_thr();
        t_dma();
        t_overrun();
        t_illegal();
        t_flush();
        t_soft();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule